// File: doc/BRIEF.md
# Single-Cycle Load/Store Processor Datapath

This block is a 32-bit processor datapath that executes every instruction in one clock period. In that period it fetches a word from a small internal instruction array at the program counter and decodes it. It reads up to two source registers, computes in the ALU, and optionally reads or writes a small internal data array. It then selects the value to write back into the register file. The supported set is three-register add, subtract, and, or and set-less-than. It also covers add, and, or and set-less-than with an immediate, word load, word store, and branches on equal and not-equal. Steering is done by explicit select signals: destination select, second-operand select, writeback select and next-PC select. The branch decision comes from the ALU zero flag after a subtraction of the two register operands.

The instruction array is filled through a load port, normally while reset is held. After reset is released the core runs the program. Each cycle it shows the current program counter, the register write it is about to commit and the store it is about to commit. A surrounding test environment can follow execution from these outputs without looking inside.

Top module: `sc_core`

## Requirements
- R1: A synchronous active-high reset sets the program counter to 0 and clears all 32 registers. While reset is high, no register or data-array write is committed and `wb_en_o` and `st_en_o` read 0.
- R2: For any instruction other than a taken branch, the program counter on the next rising edge is the current value plus 4.
- R3: Opcode 000000 with shift field [10:6] zero and function field [5:0] of 100000 (add), 100010 (subtract), 100100 (and) or 100101 (or) writes the result of rs [25:21] op rt [20:16] into register rd [15:11].
- R4: Opcode 001000 (add immediate) sign-extends the 16-bit immediate [15:0]. Opcodes 001100 (and immediate) and 001101 (or immediate) zero-extend it. Each writes the result with rs into register rt [20:16].
- R5: Function 101010 (set-less-than, written to rd) and opcode 001010 (set-less-than immediate, sign-extended, written to rt) write 1 when the first operand is less than the second as signed values, else 0.
- R6: Opcode 101011 (store) writes register rt to the data word at rs plus the sign-extended immediate, shows that address and data on `st_addr_o`/`st_data_o` with `st_en_o` high, and writes no register.
- R7: Opcode 100011 (load) writes the data word at rs plus the sign-extended immediate into register rt. The data array is never read and written in the same cycle.
- R8: Opcode 000100 branches when rs equals rt, and opcode 000101 branches when they differ. A taken branch loads PC+4 plus the sign-extended immediate shifted left by 2. Branches write neither a register nor the data array.
- R9: Register 0 always reads as 0. A write aimed at it is shown on the writeback outputs but leaves it at 0.
- R10: Any other opcode, an unlisted function code, or a three-register word with a nonzero shift field writes nothing and advances the program counter by 4.
- R11: With `load_en` high, the word on `load_word` is written at the rising edge into instruction slot `load_idx` (the slot fetched when PC[7:2] equals it).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| load_en | input | 1 | Write enable for the instruction array |
| load_idx | input | 6 | Instruction word slot to write |
| load_word | input | 32 | Instruction word to write |
| pc_o | output | 32 | Current program counter |
| wb_en_o | output | 1 | A register write is committed at the next edge |
| wb_reg_o | output | 5 | Destination register number |
| wb_data_o | output | 32 | Value written back |
| st_en_o | output | 1 | A data store is committed at the next edge |
| st_addr_o | output | 32 | Byte address of the store |
| st_data_o | output | 32 | Word being stored |

## Verification
The hardest path to reach from the ports is a backward branch that lands on an instruction that was skipped earlier. It needs a not-equal branch with a negative offset whose operands were produced several instructions before. The stimulus builds those operands with immediates and then places a forward equal branch that jumps over a slot. A later backward branch returns into that slot, and a second forward branch leaves the loop. A write aimed at register 0 is followed by a read of register 0, so an ignored write shows up in a later sum. The program is reloaded under reset so that a sum of cleared registers proves the clear.

// File: rtl/sc_pkg.sv
package sc_pkg;

    localparam int XLEN = 32;
    localparam int NREG = 32;
    localparam int RIDX = $clog2(NREG);

    // Major opcodes, bits [31:26]
    localparam logic [5:0] OPC_RTYPE = 6'b000000;
    localparam logic [5:0] OPC_BEQ   = 6'b000100;
    localparam logic [5:0] OPC_BNE   = 6'b000101;
    localparam logic [5:0] OPC_ADDI  = 6'b001000;
    localparam logic [5:0] OPC_SLTI  = 6'b001010;
    localparam logic [5:0] OPC_ANDI  = 6'b001100;
    localparam logic [5:0] OPC_ORI   = 6'b001101;
    localparam logic [5:0] OPC_LW    = 6'b100011;
    localparam logic [5:0] OPC_SW    = 6'b101011;

    // Function codes, bits [5:0], for the three-register format
    localparam logic [5:0] FN_ADD = 6'b100000;
    localparam logic [5:0] FN_SUB = 6'b100010;
    localparam logic [5:0] FN_AND = 6'b100100;
    localparam logic [5:0] FN_OR  = 6'b100101;
    localparam logic [5:0] FN_SLT = 6'b101010;

    typedef enum logic [3:0] {
        ALU_AND = 4'b0000,
        ALU_OR  = 4'b0001,
        ALU_ADD = 4'b0010,
        ALU_SUB = 4'b0110,
        ALU_SLT = 4'b0111
    } alu_op_e;

    typedef struct packed {
        logic    reg_dst;     // 1: rd field, 0: rt field
        logic    alu_src;     // 1: extended immediate, 0: rt data
        logic    reg_write;
        logic    mem_read;
        logic    mem_write;
        logic    mem_to_reg;  // 1: loaded word, 0: ALU result
        logic    branch;
        logic    branch_ne;   // branch when zero flag is clear
        logic    imm_zext;    // zero-extend instead of sign-extend
        alu_op_e alu_op;
    } ctrl_t;

    function automatic logic [XLEN-1:0] ext_imm(input logic [15:0] imm, input logic zext);
        logic fill;
        fill = zext ? 1'b0 : imm[15];
        return {{(XLEN-16){fill}}, imm};
    endfunction

endpackage

// File: rtl/sc_decode.sv
module sc_decode
    import sc_pkg::*;
(
    input  logic [XLEN-1:0] instr,
    output ctrl_t           ctrl
);

    logic [5:0] opc;
    logic [5:0] fn;
    logic       shamt_zero;

    assign opc        = instr[31:26];
    assign fn         = instr[5:0];
    assign shamt_zero = (instr[10:6] == 5'd0);

    always_comb begin
        ctrl        = '0;
        ctrl.alu_op = ALU_ADD;
        case (opc)
            OPC_RTYPE: begin
                ctrl.reg_dst   = 1'b1;
                ctrl.reg_write = shamt_zero;
                case (fn)
                    FN_ADD:  ctrl.alu_op = ALU_ADD;
                    FN_SUB:  ctrl.alu_op = ALU_SUB;
                    FN_AND:  ctrl.alu_op = ALU_AND;
                    FN_OR:   ctrl.alu_op = ALU_OR;
                    FN_SLT:  ctrl.alu_op = ALU_SLT;
                    default: ctrl.reg_write = 1'b0;
                endcase
            end
            OPC_ADDI: begin
                ctrl.alu_src   = 1'b1;
                ctrl.reg_write = 1'b1;
            end
            OPC_SLTI: begin
                ctrl.alu_src   = 1'b1;
                ctrl.reg_write = 1'b1;
                ctrl.alu_op    = ALU_SLT;
            end
            OPC_ANDI: begin
                ctrl.alu_src   = 1'b1;
                ctrl.reg_write = 1'b1;
                ctrl.imm_zext  = 1'b1;
                ctrl.alu_op    = ALU_AND;
            end
            OPC_ORI: begin
                ctrl.alu_src   = 1'b1;
                ctrl.reg_write = 1'b1;
                ctrl.imm_zext  = 1'b1;
                ctrl.alu_op    = ALU_OR;
            end
            OPC_LW: begin
                ctrl.alu_src    = 1'b1;
                ctrl.reg_write  = 1'b1;
                ctrl.mem_read   = 1'b1;
                ctrl.mem_to_reg = 1'b1;
            end
            OPC_SW: begin
                ctrl.alu_src   = 1'b1;
                ctrl.mem_write = 1'b1;
            end
            OPC_BEQ: begin
                ctrl.branch = 1'b1;
                ctrl.alu_op = ALU_SUB;
            end
            OPC_BNE: begin
                ctrl.branch    = 1'b1;
                ctrl.branch_ne = 1'b1;
                ctrl.alu_op    = ALU_SUB;
            end
            default: ctrl.alu_op = ALU_ADD;
        endcase
    end

endmodule

// File: rtl/sc_regfile.sv
module sc_regfile #(
    parameter  int W  = 32,
    parameter  int N  = 32,
    localparam int AW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] ra1,
    input  logic [AW-1:0] ra2,
    input  logic          we,
    input  logic [AW-1:0] wa,
    input  logic [W-1:0]  wd,
    output logic [W-1:0]  rd1,
    output logic [W-1:0]  rd2
);

    logic [W-1:0] regs [N];
    logic [AW-1:0] ra [2];
    logic [W-1:0]  rd [2];

    assign ra[0] = ra1;
    assign ra[1] = ra2;
    assign rd1   = rd[0];
    assign rd2   = rd[1];

    // Two identical read ports; slot zero is hard-wired to zero
    for (genvar p = 0; p < 2; p++) begin : g_rport
        assign rd[p] = (ra[p] == '0) ? '0 : regs[ra[p]];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < N; i++) regs[i] <= '0;
        end else if (we && (wa != '0)) begin
            regs[wa] <= wd;
        end
    end

endmodule

// File: rtl/sc_alu.sv
module sc_alu
    import sc_pkg::*;
#(
    parameter int W = 32
) (
    input  alu_op_e      op,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] y,
    output logic         zero
);

    always_comb begin
        case (op)
            ALU_AND: y = a & b;
            ALU_OR:  y = a | b;
            ALU_ADD: y = a + b;
            ALU_SUB: y = a - b;
            ALU_SLT: y = {{(W-1){1'b0}}, ($signed(a) < $signed(b))};
            default: y = '0;
        endcase
    end

    assign zero = (y == '0);

endmodule

// File: rtl/sc_core.sv
module sc_core
    import sc_pkg::*;
#(
    parameter  int IMEM_WORDS = 64,
    parameter  int DMEM_WORDS = 64,
    localparam int IAW        = $clog2(IMEM_WORDS),
    localparam int DAW        = $clog2(DMEM_WORDS)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            load_en,
    input  logic [IAW-1:0]  load_idx,
    input  logic [XLEN-1:0] load_word,
    output logic [XLEN-1:0] pc_o,
    output logic            wb_en_o,
    output logic [RIDX-1:0] wb_reg_o,
    output logic [XLEN-1:0] wb_data_o,
    output logic            st_en_o,
    output logic [XLEN-1:0] st_addr_o,
    output logic [XLEN-1:0] st_data_o
);

    logic [XLEN-1:0] imem [IMEM_WORDS];
    logic [XLEN-1:0] dmem [DMEM_WORDS];

    logic [XLEN-1:0] pc_q, pc_plus4, br_tgt, pc_next;
    logic [XLEN-1:0] instr, rs_data, rt_data, imm_ext, alu_b, alu_y;
    logic [XLEN-1:0] rd_word, wb_data;
    logic [RIDX-1:0] dst;
    logic            alu_zero, take, rf_we, dm_we;
    ctrl_t           ctrl;

    // Instruction array: written through the load port, read at the PC
    always_ff @(posedge clk) begin
        if (load_en) imem[load_idx] <= load_word;
    end
    assign instr = imem[pc_q[IAW+1:2]];

    sc_decode u_dec (
        .instr (instr),
        .ctrl  (ctrl)
    );

    // Destination select
    assign dst   = ctrl.reg_dst ? instr[15:11] : instr[20:16];
    assign rf_we = ctrl.reg_write & ~rst;
    assign dm_we = ctrl.mem_write & ~rst;

    sc_regfile #(.W(XLEN), .N(NREG)) u_rf (
        .clk (clk),
        .rst (rst),
        .ra1 (instr[25:21]),
        .ra2 (instr[20:16]),
        .we  (rf_we),
        .wa  (dst),
        .wd  (wb_data),
        .rd1 (rs_data),
        .rd2 (rt_data)
    );

    // Second operand select
    assign imm_ext = ext_imm(instr[15:0], ctrl.imm_zext);
    assign alu_b   = ctrl.alu_src ? imm_ext : rt_data;

    sc_alu #(.W(XLEN)) u_alu (
        .op   (ctrl.alu_op),
        .a    (rs_data),
        .b    (alu_b),
        .y    (alu_y),
        .zero (alu_zero)
    );

    // Data array: word addressed by the ALU result
    always_ff @(posedge clk) begin
        if (dm_we) dmem[alu_y[DAW+1:2]] <= rt_data;
    end
    assign rd_word = ctrl.mem_read ? dmem[alu_y[DAW+1:2]] : '0;

    // Writeback select
    assign wb_data = ctrl.mem_to_reg ? rd_word : alu_y;

    // Next-PC select
    assign pc_plus4 = pc_q + XLEN'(4);
    assign br_tgt   = pc_plus4 + {imm_ext[XLEN-3:0], 2'b00};
    assign take     = ctrl.branch & (alu_zero ^ ctrl.branch_ne);
    assign pc_next  = take ? br_tgt : pc_plus4;

    always_ff @(posedge clk) begin
        if (rst) pc_q <= '0;
        else     pc_q <= pc_next;
    end

    assign pc_o      = pc_q;
    assign wb_en_o   = rf_we;
    assign wb_reg_o  = dst;
    assign wb_data_o = wb_data;
    assign st_en_o   = dm_we;
    assign st_addr_o = alu_y;
    assign st_data_o = rt_data;

endmodule

// File: rtl/sc_core_chk.sv
module sc_core_chk
    import sc_pkg::*;
#(
    parameter int W = 32
) (
    input logic         clk,
    input logic         rst,
    input logic [W-1:0] pc,
    input logic [5:0]   opc,
    input logic [4:0]   rs,
    input logic [15:0]  imm,
    input logic [W-1:0] rs_data,
    input logic [W-1:0] rt_data,
    input logic         wb_en,
    input logic         st_en,
    input logic         rd_en
);

    // R7
    mem_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(rd_en && st_en));

    // R2
    seq_pc_chk: assert property (@(posedge clk) disable iff (rst)
        (opc != OPC_BEQ && opc != OPC_BNE) |=> (pc == $past(pc) + W'(4)));

    // R8
    br_take_chk: assert property (@(posedge clk) disable iff (rst)
        ((opc == OPC_BEQ && rs_data == rt_data) || (opc == OPC_BNE && rs_data != rt_data))
        |=> (pc == $past(pc) + W'(4) + {{(W-18){$past(imm[15])}}, $past(imm), 2'b00}));

    // R8
    br_fall_chk: assert property (@(posedge clk) disable iff (rst)
        ((opc == OPC_BEQ && rs_data != rt_data) || (opc == OPC_BNE && rs_data == rt_data))
        |=> (pc == $past(pc) + W'(4)));

    // R8
    br_nowrite_chk: assert property (@(posedge clk) disable iff (rst)
        (opc == OPC_BEQ || opc == OPC_BNE) |-> (!wb_en && !st_en));

    // R6
    st_nowb_chk: assert property (@(posedge clk) disable iff (rst)
        (opc == OPC_SW) |-> (st_en && !wb_en));

    // R9
    r0_read_chk: assert property (@(posedge clk) disable iff (rst)
        (rs == 5'd0) |-> (rs_data == '0));

endmodule

bind sc_core sc_core_chk #(.W(sc_pkg::XLEN)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .pc      (pc_o),
    .opc     (instr[31:26]),
    .rs      (instr[25:21]),
    .imm     (instr[15:0]),
    .rs_data (rs_data),
    .rt_data (rt_data),
    .wb_en   (wb_en_o),
    .st_en   (st_en_o),
    .rd_en   (ctrl.mem_read)
);

// File: tb/sc_core_tb.sv
module sc_core_tb;

    localparam int IAW = 6;
    localparam int NR  = 25;

    localparam logic [5:0] T_ADDI = 6'b001000, T_SLTI = 6'b001010, T_ANDI = 6'b001100;
    localparam logic [5:0] T_ORI  = 6'b001101, T_LW   = 6'b100011, T_SW   = 6'b101011;
    localparam logic [5:0] T_BEQ  = 6'b000100, T_BNE  = 6'b000101;
    localparam logic [5:0] F_ADD  = 6'b100000, F_SUB  = 6'b100010, F_AND  = 6'b100100;
    localparam logic [5:0] F_OR   = 6'b100101, F_SLT  = 6'b101010;

    function automatic logic [31:0] r_fmt(input logic [5:0] fn, input int rd, input int rs, input int rt);
        return {6'b000000, rs[4:0], rt[4:0], rd[4:0], 5'b00000, fn};
    endfunction

    function automatic logic [31:0] i_fmt(input logic [5:0] op, input int rt, input int rs, input logic [15:0] imm);
        return {op, rs[4:0], rt[4:0], imm};
    endfunction

    typedef struct packed {
        logic [31:0] pc;
        logic [31:0] ins;
        logic        we;
        logic [4:0]  wr;
        logic [31:0] wd;
        logic        se;
        logic [31:0] sa;
        logic [31:0] sd;
        logic [3:0]  req;
    } row_t;

    // Execution trace: one row per clock, in the order instructions run
    localparam row_t TBL [NR] = '{
        '{32'd0,   i_fmt(T_ADDI, 1, 0, 16'd5),       1'b1, 5'd1,  32'd5,         1'b0, 32'd0, 32'd0,      4'd4},  // R4
        '{32'd4,   i_fmt(T_ADDI, 2, 0, 16'hFFFD),    1'b1, 5'd2,  32'hFFFFFFFD,  1'b0, 32'd0, 32'd0,      4'd4},  // R4
        '{32'd8,   r_fmt(F_ADD, 3, 1, 2),            1'b1, 5'd3,  32'd2,         1'b0, 32'd0, 32'd0,      4'd3},  // R3
        '{32'd12,  r_fmt(F_SUB, 4, 1, 2),            1'b1, 5'd4,  32'd8,         1'b0, 32'd0, 32'd0,      4'd3},  // R3
        '{32'd16,  r_fmt(F_AND, 5, 1, 2),            1'b1, 5'd5,  32'd5,         1'b0, 32'd0, 32'd0,      4'd3},  // R3
        '{32'd20,  r_fmt(F_OR, 6, 1, 2),             1'b1, 5'd6,  32'hFFFFFFFD,  1'b0, 32'd0, 32'd0,      4'd3},  // R3
        '{32'd24,  r_fmt(F_SLT, 7, 2, 1),            1'b1, 5'd7,  32'd1,         1'b0, 32'd0, 32'd0,      4'd5},  // R5
        '{32'd28,  r_fmt(F_SLT, 8, 1, 2),            1'b1, 5'd8,  32'd0,         1'b0, 32'd0, 32'd0,      4'd5},  // R5
        '{32'd32,  i_fmt(T_SLTI, 9, 2, 16'd0),       1'b1, 5'd9,  32'd1,         1'b0, 32'd0, 32'd0,      4'd5},  // R5
        '{32'd36,  i_fmt(T_ANDI, 10, 2, 16'hFF00),   1'b1, 5'd10, 32'h0000FF00,  1'b0, 32'd0, 32'd0,      4'd4},  // R4
        '{32'd40,  i_fmt(T_ORI, 11, 0, 16'h8001),    1'b1, 5'd11, 32'h00008001,  1'b0, 32'd0, 32'd0,      4'd4},  // R4
        '{32'd44,  i_fmt(T_SW, 11, 0, 16'd8),        1'b0, 5'd0,  32'd0,         1'b1, 32'd8, 32'h8001,   4'd6},  // R6
        '{32'd48,  i_fmt(T_LW, 12, 0, 16'd8),        1'b1, 5'd12, 32'h00008001,  1'b0, 32'd0, 32'd0,      4'd7},  // R7
        '{32'd52,  i_fmt(T_ADDI, 0, 0, 16'd7),       1'b1, 5'd0,  32'd7,         1'b0, 32'd0, 32'd0,      4'd9},  // R9
        '{32'd56,  r_fmt(F_ADD, 13, 0, 1),           1'b1, 5'd13, 32'd5,         1'b0, 32'd0, 32'd0,      4'd9},  // R9
        '{32'd60,  i_fmt(T_BEQ, 2, 1, 16'd4),        1'b0, 5'd0,  32'd0,         1'b0, 32'd0, 32'd0,      4'd8},  // R8 not taken
        '{32'd64,  i_fmt(T_BEQ, 3, 3, 16'd2),        1'b0, 5'd0,  32'd0,         1'b0, 32'd0, 32'd0,      4'd8},  // R8 taken to 76
        '{32'd76,  i_fmt(T_BNE, 1, 1, 16'd5),        1'b0, 5'd0,  32'd0,         1'b0, 32'd0, 32'd0,      4'd8},  // R8 not taken
        '{32'd80,  i_fmt(T_BNE, 2, 1, 16'hFFFC),     1'b0, 5'd0,  32'd0,         1'b0, 32'd0, 32'd0,      4'd8},  // R8 back to 68
        '{32'd68,  i_fmt(T_ADDI, 14, 0, 16'd9),      1'b1, 5'd14, 32'd9,         1'b0, 32'd0, 32'd0,      4'd2},  // R2
        '{32'd72,  i_fmt(T_BEQ, 0, 0, 16'd5),        1'b0, 5'd0,  32'd0,         1'b0, 32'd0, 32'd0,      4'd8},  // R8 taken to 96
        '{32'd96,  i_fmt(T_SW, 1, 4, 16'hFFFC),      1'b0, 5'd0,  32'd0,         1'b1, 32'd4, 32'd5,      4'd6},  // R6
        '{32'd100, i_fmt(T_LW, 15, 0, 16'd4),        1'b1, 5'd15, 32'd5,         1'b0, 32'd0, 32'd0,      4'd7},  // R7
        '{32'd104, i_fmt(T_SLTI, 16, 1, 16'hFFFF),   1'b1, 5'd16, 32'd0,         1'b0, 32'd0, 32'd0,      4'd5},  // R5
        '{32'd108, r_fmt(F_ADD, 17, 15, 3),          1'b1, 5'd17, 32'd7,         1'b0, 32'd0, 32'd0,      4'd3}   // R3
    };

    logic           clk = 1'b0;
    logic           rst;
    logic           load_en;
    logic [IAW-1:0] load_idx;
    logic [31:0]    load_word;
    logic [31:0]    pc_o, wb_data_o, st_addr_o, st_data_o;
    logic [4:0]     wb_reg_o;
    logic           wb_en_o, st_en_o;

    int n_chk = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    sc_core u_dut (
        .clk       (clk),
        .rst       (rst),
        .load_en   (load_en),
        .load_idx  (load_idx),
        .load_word (load_word),
        .pc_o      (pc_o),
        .wb_en_o   (wb_en_o),
        .wb_reg_o  (wb_reg_o),
        .wb_data_o (wb_data_o),
        .st_en_o   (st_en_o),
        .st_addr_o (st_addr_o),
        .st_data_o (st_data_o)
    );

    task automatic chk(input bit ok, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", what, act, exp);
        end
    endtask

    task automatic load(input int idx, input logic [31:0] w);
        @(negedge clk);
        load_en   = 1'b1;
        load_idx  = idx[IAW-1:0];
        load_word = w;
    endtask

    task automatic finish_run();
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired (R2 flow) actual=%h expected=end of program", pc_o);
        finish_run();
    end

    initial begin
        rst = 1'b1; load_en = 1'b0; load_idx = '0; load_word = '0;
        repeat (2) @(negedge clk);

        // R11: program loaded through the port while reset holds
        for (int i = 0; i < 64; i++) load(i, 32'd0);
        for (int k = 0; k < NR; k++) load(int'(TBL[k].pc[7:2]), TBL[k].ins);
        @(negedge clk);
        load_en = 1'b0;

        // R1: reset state
        chk(pc_o == 32'd0, "R1 pc under reset", pc_o, 32'd0);
        chk(!wb_en_o && !st_en_o, "R1 no commit under reset", {30'd0, wb_en_o, st_en_o}, 32'd0);

        rst = 1'b0;
        #1;
        for (int k = 0; k < NR; k++) begin
            chk(pc_o == TBL[k].pc, $sformatf("R%0d/R2 row %0d pc", TBL[k].req, k), pc_o, TBL[k].pc);
            chk(wb_en_o == TBL[k].we, $sformatf("R%0d row %0d wb_en", TBL[k].req, k),
                {31'd0, wb_en_o}, {31'd0, TBL[k].we});
            if (TBL[k].we) begin
                chk(wb_reg_o == TBL[k].wr, $sformatf("R%0d row %0d wb_reg", TBL[k].req, k),
                    {27'd0, wb_reg_o}, {27'd0, TBL[k].wr});
                chk(wb_data_o == TBL[k].wd, $sformatf("R%0d row %0d wb_data", TBL[k].req, k),
                    wb_data_o, TBL[k].wd);
            end
            chk(st_en_o == TBL[k].se, $sformatf("R%0d row %0d st_en", TBL[k].req, k),
                {31'd0, st_en_o}, {31'd0, TBL[k].se});
            if (TBL[k].se) begin
                chk(st_addr_o == TBL[k].sa, $sformatf("R%0d row %0d st_addr", TBL[k].req, k),
                    st_addr_o, TBL[k].sa);
                chk(st_data_o == TBL[k].sd, $sformatf("R%0d row %0d st_data", TBL[k].req, k),
                    st_data_o, TBL[k].sd);
            end
            @(negedge clk);
        end

        // Directed: reset mid-run, reload, unsupported words
        rst = 1'b1;
        load(0, 32'hFC00_0000);                      // unknown opcode
        load(1, 32'h0000_0000);                      // unlisted function code
        load(2, r_fmt(F_ADD, 17, 1, 0));             // sum of cleared registers
        load(3, r_fmt(F_ADD, 18, 1, 1) | 32'h40);    // nonzero shift field
        @(negedge clk);
        load_en = 1'b0;
        chk(pc_o == 32'd0, "R1 pc after mid-run reset", pc_o, 32'd0);

        rst = 1'b0;
        #1;
        chk(!wb_en_o && !st_en_o, "R10 unknown opcode commits nothing", {30'd0, wb_en_o, st_en_o}, 32'd0);
        @(negedge clk);
        chk(pc_o == 32'd4, "R10 pc after unknown opcode", pc_o, 32'd4);
        chk(!wb_en_o && !st_en_o, "R10 unlisted function commits nothing", {30'd0, wb_en_o, st_en_o}, 32'd0);
        @(negedge clk);
        chk(pc_o == 32'd8, "R10 pc after unlisted function", pc_o, 32'd8);
        chk(wb_en_o && wb_reg_o == 5'd17, "R11 reloaded word decoded", {26'd0, wb_en_o, wb_reg_o},
            {26'd0, 1'b1, 5'd17});
        chk(wb_data_o == 32'd0, "R1 registers cleared by reset", wb_data_o, 32'd0);
        @(negedge clk);
        chk(!wb_en_o, "R10 nonzero shift field writes nothing", {31'd0, wb_en_o}, 32'd0);
        @(negedge clk);
        chk(pc_o == 32'd16, "R10 pc after nonzero shift field", pc_o, 32'd16);

        finish_run();
    end

endmodule